// File: doc/BRIEF.md
# Truncated Exponential Backoff Timer

This block times the random pause that a half-duplex Ethernet MAC takes after a collision. When the MAC reports a collision it also gives the retry number of the frame and a 2-bit limit setting. The block forms the exponent K as the smaller of the retry number and ten. It caps that exponent with the bit count chosen by the limit setting, which gives a relaxed or an aggressive backoff. It then takes that many low bits from a free-running 20-bit LFSR as the wait, in slot times.

The wait is loaded into a down-counter. A prescaler turns bit-time ticks into slot-time ticks of 512 bit times, and each slot tick lowers the counter by one. When the counter has reached zero, a one-cycle done pulse tells the MAC it may try again. A collision during a countdown restarts the wait with a fresh random value.

Top module: `backoff_timer`

## Requirements
- R1: On a collision strobe the exponent is K = min(retry_cnt_i, 10). A retry count of 0 gives K = 0 and a wait of zero.
- R2: The limit setting caps the bit count: limit_sel_i = 2'b00 allows 10 bits, 2'b01 allows 8, 2'b10 allows 4 and 2'b11 allows 1.
- R3: The loaded wait equals the LFSR's state bits [nb-1:0] at the strobe clock edge, zero-extended, where nb = min(K, limit bit count). It is visible on wait_slots_o from the clock after the strobe.
- R4: The LFSR resets to 20'h00001. On every clock it shifts left, taking as its new bit 0 the XOR of state bits 19 and 16. It never holds all zeros.
- R5: While busy, a slot tick occurs on every 512th bit_tick_i counted since the load, and each slot tick lowers wait_slots_o by one. With a tick on every clock, a wait of v gives done_o exactly 512*v+1 clocks after the load edge.
- R6: done_o is a single-cycle pulse in the clock after the counter holds zero while busy, and busy_o is low while done_o is high.
- R7: A loaded wait of zero gives done_o on the next clock, with no slot time spent.
- R8: A collision strobe while busy reloads the counter with a fresh random value and restarts the slot prescaler, so bit ticks counted before the reload have no effect on the new wait.
- R9: After reset busy_o, done_o and wait_slots_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| collision_i | input | 1 | One-cycle collision strobe that starts or restarts a backoff |
| retry_cnt_i | input | 5 | Retry number of the current frame |
| limit_sel_i | input | 2 | Backoff limit setting (bit-count cap) |
| bit_tick_i | input | 1 | One pulse per bit time |
| busy_o | output | 1 | Backoff in progress |
| wait_slots_o | output | 10 | Remaining wait in slot times |
| done_o | output | 1 | One-cycle pulse when the wait has elapsed |

## Verification
The exponent and mask path is driven with retry counts below, at and above ten. Each is crossed with all four limit settings, so a wrong cap, a wrong minimum or a wrong mapping of the limit code shows up as an extra or missing bit in the loaded wait. A bench model of the shift register predicts the exact value, which separates wrong taps or a wrong seed from a correct mask. Strobes placed back to back show that a reload replaces the wait. A timed countdown, begun after a partly counted slot has been discarded, tells the 512-tick slot length and the prescaler restart apart from off-by-one errors. The zero-wait case is checked separately.

// File: rtl/backoff_pkg.sv
// Shared constants and helpers for the backoff timer.
// Assumes a 2-bit limit setting with a fixed bit-count mapping.
package backoff_pkg;

    localparam int EXP_W = 4;

    // Map the limit setting to the largest number of random bits allowed.
    function automatic logic [EXP_W-1:0] limit_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   limit_bits = EXP_W'(10);
            2'b01:   limit_bits = EXP_W'(8);
            2'b10:   limit_bits = EXP_W'(4);
            default: limit_bits = EXP_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
// Free-running Fibonacci LFSR used as the random source.
// Assumes SEED is nonzero and the taps describe a maximal-length polynomial.
module bo_lfsr #(
    parameter int          W     = 20,
    parameter int          TAP_A = 20,
    parameter int          TAP_B = 17,
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;

    // Advance the shift register once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[W-2:0], state_q[TAP_A-1] ^ state_q[TAP_B-1]};
    end

    assign state_o = state_q;

endmodule

// File: rtl/bo_exp_select.sv
// Combinational exponent, cap and mask selection.
// Assumes WAIT_W is the largest exponent allowed by the backoff rules.
module bo_exp_select
    import backoff_pkg::*;
#(
    parameter int RETRY_W = 5,
    parameter int WAIT_W  = 10
) (
    input  logic [RETRY_W-1:0] retry_i,
    input  logic [1:0]         limit_i,
    input  logic [WAIT_W-1:0]  rand_i,
    output logic [WAIT_W-1:0]  wait_o
);

    localparam int MAX_EXP = WAIT_W;

    logic [EXP_W-1:0]  exp_k;
    logic [EXP_W-1:0]  cap;
    logic [EXP_W-1:0]  nbits;
    logic [WAIT_W-1:0] mask;

    // Clamp the retry count, apply the limit cap and mask the random bits.
    always_comb begin
        if (retry_i > RETRY_W'(MAX_EXP)) exp_k = EXP_W'(MAX_EXP);
        else                             exp_k = EXP_W'(retry_i);
        cap   = limit_bits(limit_i);
        nbits = (exp_k < cap) ? exp_k : cap;
        mask  = ~({WAIT_W{1'b1}} << nbits);
        wait_o = rand_i & mask;
    end

endmodule

// File: rtl/bo_prescaler.sv
// Divides bit-time ticks into slot-time ticks.
// Assumes restart has priority and that counting happens only while enabled.
module bo_prescaler #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic enable_i,
    input  logic bit_tick_i,
    output logic slot_tick_o
);

    localparam int PRE_W = $clog2(SLOT_BITS);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(SLOT_BITS - 1);

    logic [PRE_W-1:0] cnt_q;

    // Count bit ticks within the current slot, wrapping at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (restart_i)                cnt_q <= '0;
        else if (enable_i && bit_tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign slot_tick_o = enable_i && bit_tick_i && !restart_i && (cnt_q == LAST);

endmodule

// File: rtl/bo_wait_counter.sv
// Holds the remaining wait and issues the done pulse.
// Assumes load has priority over counting and over completion.
module bo_wait_counter #(
    parameter int WAIT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              slot_tick_i,
    output logic              busy_o,
    output logic [WAIT_W-1:0] count_o,
    output logic              done_o
);

    logic              active_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              done_q;

    // Load, count down per slot, and finish one clock after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                active_q <= 1'b1;
                cnt_q    <= load_val_i;
            end else if (active_q) begin
                if (cnt_q == '0) begin
                    done_q   <= 1'b1;
                    active_q <= 1'b0;
                end else if (slot_tick_i) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o  = active_q;
    assign count_o = cnt_q;
    assign done_o  = done_q;

endmodule

// File: rtl/backoff_timer.sv
// Top level: truncated exponential backoff timer for a half-duplex MAC.
// Assumes collision_i is a one-cycle strobe and bit_tick_i pulses once per bit time.
module backoff_timer #(
    parameter int RETRY_W   = 5,
    parameter int WAIT_W    = 10,
    parameter int LFSR_W    = 20,
    parameter int SLOT_BITS = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               collision_i,
    input  logic [RETRY_W-1:0] retry_cnt_i,
    input  logic [1:0]         limit_sel_i,
    input  logic               bit_tick_i,
    output logic               busy_o,
    output logic [WAIT_W-1:0]  wait_slots_o,
    output logic               done_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [WAIT_W-1:0] new_wait;
    logic              slot_tick;

    bo_lfsr #(
        .W     (LFSR_W),
        .TAP_A (20),
        .TAP_B (17),
        .SEED  (LFSR_W'(1))
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr_q)
    );

    bo_exp_select #(
        .RETRY_W (RETRY_W),
        .WAIT_W  (WAIT_W)
    ) sel_i (
        .retry_i (retry_cnt_i),
        .limit_i (limit_sel_i),
        .rand_i  (lfsr_q[WAIT_W-1:0]),
        .wait_o  (new_wait)
    );

    bo_prescaler #(
        .SLOT_BITS (SLOT_BITS)
    ) pre_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (collision_i),
        .enable_i    (busy_o),
        .bit_tick_i  (bit_tick_i),
        .slot_tick_o (slot_tick)
    );

    bo_wait_counter #(
        .WAIT_W (WAIT_W)
    ) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (collision_i),
        .load_val_i  (new_wait),
        .slot_tick_i (slot_tick),
        .busy_o      (busy_o),
        .count_o     (wait_slots_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/backoff_timer_checker.sv
// Property checker for backoff_timer, attached through bind.
module backoff_timer_checker #(
    parameter int RETRY_W = 5,
    parameter int WAIT_W  = 10,
    parameter int LFSR_W  = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               collision_i,
    input logic [RETRY_W-1:0] retry_cnt_i,
    input logic [1:0]         limit_sel_i,
    input logic               busy_o,
    input logic [WAIT_W-1:0]  wait_slots_o,
    input logic               done_o,
    input logic [LFSR_W-1:0]  lfsr_state
);

    // Upper bound of a loaded wait, from the previous cycle's inputs.
    function automatic int wait_bound(input logic [RETRY_W-1:0] r, input logic [1:0] l);
        int k;
        int c;
        k = (int'(r) > WAIT_W) ? WAIT_W : int'(r);
        c = (l == 2'b00) ? 10 : (l == 2'b01) ? 8 : (l == 2'b10) ? 4 : 1;
        if (c < k) k = c;
        return (1 << k) - 1;
    endfunction

    AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        collision_i |=> busy_o && (int'(wait_slots_o) <= wait_bound($past(retry_cnt_i), $past(limit_sel_i)))); // R3

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !collision_i) |=> (wait_slots_o == $past(wait_slots_o)) ||
                                     (wait_slots_o == $past(wait_slots_o) - 1'b1)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wait_slots_o == '0 && !collision_i) |=> done_o); // R7

    AST_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && collision_i) |=> busy_o && !done_o); // R8

endmodule

bind backoff_timer backoff_timer_checker #(
    .RETRY_W (RETRY_W),
    .WAIT_W  (WAIT_W),
    .LFSR_W  (LFSR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .collision_i  (collision_i),
    .retry_cnt_i  (retry_cnt_i),
    .limit_sel_i  (limit_sel_i),
    .busy_o       (busy_o),
    .wait_slots_o (wait_slots_o),
    .done_o       (done_o),
    .lfsr_state   (lfsr_q)
);

// File: tb/backoff_timer_tb_top.sv
module backoff_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       collision_i = 1'b0;
    logic [4:0] retry_cnt_i = '0;
    logic [1:0] limit_sel_i = '0;
    logic       bit_tick_i = 1'b0;
    logic       busy_o;
    logic [9:0] wait_slots_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    backoff_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .collision_i  (collision_i),
        .retry_cnt_i  (retry_cnt_i),
        .limit_sel_i  (limit_sel_i),
        .bit_tick_i   (bit_tick_i),
        .busy_o       (busy_o),
        .wait_slots_o (wait_slots_o),
        .done_o       (done_o)
    );

    // Bench model of the random source, built from R4.
    logic [19:0] model_q;
    always @(posedge clk) begin
        if (!rst_n) model_q <= 20'h00001;
        else        model_q <= {model_q[18:0], model_q[19] ^ model_q[16]};
    end

    // Vectors: {retry[4:0], limit[1:0], expected bit count[3:0]} per R1, R2, R3.
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {5'd0,  2'b00, 4'd0},  {5'd1,  2'b00, 4'd1},  {5'd3,  2'b00, 4'd3},
        {5'd3,  2'b01, 4'd3},  {5'd7,  2'b10, 4'd4},  {5'd9,  2'b01, 4'd8},
        {5'd10, 2'b00, 4'd10}, {5'd12, 2'b00, 4'd10}, {5'd15, 2'b01, 4'd8},
        {5'd12, 2'b10, 4'd4},  {5'd20, 2'b11, 4'd1},  {5'd2,  2'b11, 4'd1},
        {5'd31, 2'b00, 4'd10}, {5'd5,  2'b10, 4'd4},  {5'd11, 2'b01, 4'd8},
        {5'd6,  2'b00, 4'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one collision; returns the wait the design should load.
    task automatic collide(input logic [4:0] r, input logic [1:0] l, input int nb, output int exp_v);
        @(negedge clk);
        retry_cnt_i = r;
        limit_sel_i = l;
        collision_i = 1'b1;
        exp_v = int'(model_q[9:0] & ~(10'h3FF << nb));
        @(negedge clk);
        collision_i = 1'b0;
    endtask

    initial begin
        int ev;
        int cycles;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy_o == 1'b0 && done_o == 1'b0 && wait_slots_o == '0, "R9",
              {busy_o, done_o, wait_slots_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Table walk: back-to-back strobes, each reloading the previous wait (R1 R2 R3 R8)
        for (int i = 0; i < NV; i++) begin
            collide(VEC[i][10:6], VEC[i][5:4], int'(VEC[i][3:0]), ev);
            check(int'(wait_slots_o) == ev && busy_o, "R3 table", int'(wait_slots_o), ev);
        end

        // R7: zero wait gives done on the next clock (R1: retry 0)
        collide(5'd0, 2'b00, 0, ev);
        check(wait_slots_o == '0 && busy_o && !done_o, "R7 loaded", int'(wait_slots_o), 0);
        @(negedge clk);
        check(done_o && !busy_o, "R7 done", {done_o, busy_o}, 2);
        @(negedge clk);
        check(!done_o && !busy_o, "R6 single pulse", {done_o, busy_o}, 0);

        // R8 + R5: partial slot counted, then reload; timing measured from reload
        ev = 0;
        while (ev == 0) collide(5'd4, 2'b10, 4, ev);
        bit_tick_i = 1'b1;
        repeat (300) @(negedge clk);
        check(int'(wait_slots_o) == ev, "R5 no slot before 512 ticks", int'(wait_slots_o), ev);
        ev = 0;
        while (ev == 0) begin
            @(negedge clk);
            retry_cnt_i = 5'd4;
            limit_sel_i = 2'b10;
            collision_i = 1'b1;
            ev = int'(model_q[3:0]);
        end
        @(negedge clk);
        collision_i = 1'b0;
        check(int'(wait_slots_o) == ev, "R8 reload value", int'(wait_slots_o), ev);
        cycles = 0;
        while (!done_o && cycles < 10000) begin
            @(negedge clk);
            cycles++;
            if (cycles == 512) check(int'(wait_slots_o) == ev - 1, "R5 first slot", int'(wait_slots_o), ev - 1);
        end
        check(cycles == 512 * ev + 1, "R5 R6 done timing", cycles, 512 * ev + 1);
        check(!busy_o, "R6 busy cleared", busy_o, 0);
        @(negedge clk);
        check(!done_o, "R6 pulse width", done_o, 0);
        bit_tick_i = 1'b0;

        // R2: limit 2'b11 with large retry gives only values 0/1, match model
        for (int j = 0; j < 4; j++) begin
            collide(5'd25, 2'b11, 1, ev);
            check(int'(wait_slots_o) == ev && wait_slots_o <= 10'd1, "R2 one bit", int'(wait_slots_o), ev);
        end

        // R4: free-running source matches seed/taps after a long idle stretch
        repeat (37) @(negedge clk);
        collide(5'd10, 2'b00, 10, ev);
        check(int'(wait_slots_o) == ev, "R4 sequence", int'(wait_slots_o), ev);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule